// File: doc/BRIEF.md
# Staged Buffer Copy Sequencer

This block stages data for secure storage in two steps. A buffer-load command carries a destination code and a payload. The payload is written into a single staging buffer, and the block remembers which target it is meant for. A copy command that comes next commits the staged data to that target after a programming delay. A copy then reports a status byte that says whether it succeeded, whether it had no qualifying load before it, or whether the target is write-locked. The five targets are the private key, the public key, the two certificate halves and the counter preset. A sixth destination, the challenge, skips the staging buffer and is written at once.

Set-protection commands lock either the two keys together or the two certificate halves together. A copy to the public key also records a one-bit hint taken from the copy parameter. A read port lets the surrounding logic see the contents of every target.

Top module: `sbc_seq`

## Requirements
- R1: After reset, busy, status_valid, key_locked, cert_locked and hint_bit are 0, and every target reads back as all zeros.
- R2: A buffer-load (cmd_op=1) stages a payload for the target picked by cmd_param. The codes are 00h private key, 20h public key, 40h certificate part 1, 60h certificate part 2 and A0h counter. A successful copy makes the target readable at rd_sel = code>>5. Keys and certificates keep the low 24 payload bytes and the counter keeps the low 4 bytes; the bytes above those read as zero.
- R3: A buffer-load with code 80h writes the low 32 payload bytes straight into the challenge (rd_sel=4). The data is readable in the cycle after the command is accepted, and the load does not qualify a following copy.
- R4: A copy (cmd_op=2) whose immediately preceding accepted command was not a qualifying load fails with status 33h and changes no target. Every accepted command clears the qualification, and that includes a failed copy, a challenge load, an other command (cmd_op=0) and a protect.
- R5: A qualified copy to an unlocked target returns status AAh and updates the target in the same cycle as the status.
- R6: busy stays high for PROG_CYCLES×LONG_PERIODS cycles for a successful key or certificate copy, for PROG_CYCLES×SHORT_PERIODS cycles for a counter copy or a protect, and for 1 cycle for a failed copy. status_valid pulses for one cycle right after busy falls.
- R7: A successful public-key copy sets hint_bit to bit 7 of the copy parameter, so 80h gives 1 and 00h gives 0. No other command changes hint_bit.
- R8: A protect (cmd_op=3) with parameter 4Ch sets key_locked, and one with 4Dh sets cert_locked. Each takes effect when its AAh status appears and stays set until reset. Any other protect parameter produces no busy, no status and no lock.
- R9: A qualified copy to a locked target returns status 55h and leaves the target unchanged. Key lock covers both keys and certificate lock covers both certificate halves.
- R10: After one successful counter copy, every later qualified counter copy returns 55h.
- R11: Commands presented while busy is high are ignored.
- R12: A buffer-load with any other destination code leaves every target unchanged and leaves no copy pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 other, 1 buffer-load, 2 copy, 3 protect |
| cmd_param | input | 8 | Destination code, copy parameter or protect parameter |
| cmd_data | input | 256 | Load payload, byte 0 in bits 7:0 |
| busy | output | 1 | Programming delay in progress |
| status_valid | output | 1 | One-cycle strobe for status |
| status | output | 8 | AAh done, 33h no staged data, 55h locked |
| key_locked | output | 1 | Key pair write lock |
| cert_locked | output | 1 | Certificate write lock |
| hint_bit | output | 1 | Public key hint bit |
| rd_sel | input | 3 | Target to read, 0..5 |
| rd_data | output | 256 | Contents of the selected target |

## Verification
The hardest case to reach is a command that arrives while a long copy is still busy. The normal driver always waits for an idle block, so it can never produce this. The bench therefore has a raw drive that presents a certificate load in the middle of a key copy. A copy issued afterwards must then return 33h, and the certificate must still read zero. The bench also puts a challenge load, an unknown destination code, an other command and a failed copy between a load and its copy. Each of these checks that the pending qualification is cleared by every kind of command that is accepted.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    typedef enum logic [2:0] {
        TGT_PRIV = 3'd0, TGT_PUB = 3'd1, TGT_CRT1 = 3'd2,
        TGT_CRT2 = 3'd3, TGT_CHAL = 3'd4, TGT_CNT = 3'd5
    } tgt_e;

    typedef enum logic [1:0] {
        OP_OTHER = 2'd0, OP_LOAD = 2'd1, OP_COPY = 2'd2, OP_PROT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PROT_NONE = 2'd0, PROT_KEY = 2'd1, PROT_CRT = 2'd2
    } prot_e;

    localparam int NUM_TGT = 6;

    localparam logic [7:0] ST_DONE      = 8'hAA;
    localparam logic [7:0] ST_NOSTAGE   = 8'h33;
    localparam logic [7:0] ST_LOCKED    = 8'h55;
    localparam logic [7:0] PAR_LOCK_KEY = 8'h4C;
    localparam logic [7:0] PAR_LOCK_CRT = 8'h4D;

    function automatic int tgt_bytes(tgt_e t, int key_b, int chal_b, int cnt_b);
        case (t)
            TGT_CHAL: return chal_b;
            TGT_CNT:  return cnt_b;
            default:  return key_b;
        endcase
    endfunction
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
    import sbc_pkg::*;
#(
    parameter int KEY_BYTES  = 24,
    parameter int CHAL_BYTES = 32,
    parameter int CNT_BYTES  = 4,
    localparam int BUF_W     = CHAL_BYTES * 8
) (
    input  logic [7:0]       param,
    input  logic [BUF_W-1:0] data_in,
    output logic             dest_ok,
    output tgt_e             tgt,
    output logic [BUF_W-1:0] data_masked
);
    int nbytes;

    always_comb begin
        dest_ok = (param[4:0] == 5'd0) && (param[7:5] <= 3'd5);
        tgt     = dest_ok ? tgt_e'(param[7:5]) : TGT_PRIV;
        nbytes  = tgt_bytes(tgt, KEY_BYTES, CHAL_BYTES, CNT_BYTES);
        for (int b = 0; b < CHAL_BYTES; b++) begin
            data_masked[b*8 +: 8] = (b < nbytes) ? data_in[b*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/sbc_timer.sv
module sbc_timer #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d    = q;
        done = q.busy && (q.cnt == '0);
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = len - CW'(1);
        end else if (done) begin
            d.busy = 1'b0;
        end else if (q.busy) begin
            d.cnt = q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;

    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt != '0) |=> q.busy);
    assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);
    assert_start_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (len != '0));
endmodule

// File: rtl/sbc_store.sv
module sbc_store
    import sbc_pkg::*;
#(
    parameter int NT = 6,
    parameter int W  = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] we,
    input  logic [W-1:0]  wdata,
    input  logic [2:0]    rd_sel,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] slot_q [NT];

    for (genvar i = 0; i < NT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)     slot_q[i] <= '0;
            else if (we[i]) slot_q[i] <= wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NT; i++) begin
            if (int'(rd_sel) == i) rd_data = slot_q[i];
        end
    end

    assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));
endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
    import sbc_pkg::*;
#(
    parameter int KEY_BYTES     = 24,
    parameter int CHAL_BYTES    = 32,
    parameter int CNT_BYTES     = 4,
    parameter int PROG_CYCLES   = 8,
    parameter int LONG_PERIODS  = 10,
    parameter int SHORT_PERIODS = 1,
    localparam int BUF_W        = CHAL_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [7:0]       cmd_param,
    input  logic [BUF_W-1:0] cmd_data,
    output logic             busy,
    output logic             status_valid,
    output logic [7:0]       status,
    output logic             key_locked,
    output logic             cert_locked,
    output logic             hint_bit,
    input  logic [2:0]       rd_sel,
    output logic [BUF_W-1:0] rd_data
);
    localparam int LONG_LEN  = PROG_CYCLES * LONG_PERIODS;
    localparam int SHORT_LEN = PROG_CYCLES * SHORT_PERIODS;
    localparam int CW        = $clog2(LONG_LEN + 1);

    typedef struct packed {
        logic             pend;
        tgt_e             pend_tgt;
        logic [BUF_W-1:0] stage;
        logic             job_commit;
        tgt_e             job_tgt;
        prot_e            job_prot;
        logic             job_hint;
        logic [7:0]       job_stat;
        logic [7:0]       stat;
        logic             stat_v;
        logic             key_lk;
        logic             crt_lk;
        logic             cnt_lk;
        logic             hint;
    } seq_t;

    seq_t q, d;

    logic             dest_ok;
    tgt_e             dec_tgt;
    logic [BUF_W-1:0] dec_data;
    logic             t_start, t_done;
    logic [CW-1:0]    t_len;
    logic [NUM_TGT-1:0] we;
    logic [BUF_W-1:0] wdata;
    logic             accept;
    logic             tgt_lk;
    op_e              op;

    sbc_decode #(.KEY_BYTES(KEY_BYTES), .CHAL_BYTES(CHAL_BYTES), .CNT_BYTES(CNT_BYTES)) u_dec (
        .param(cmd_param), .data_in(cmd_data),
        .dest_ok(dest_ok), .tgt(dec_tgt), .data_masked(dec_data)
    );

    sbc_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(t_start), .len(t_len),
        .busy(busy), .done(t_done)
    );

    sbc_store #(.NT(NUM_TGT), .W(BUF_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .wdata(wdata),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    always_comb begin
        unique case (q.pend_tgt)
            TGT_PRIV, TGT_PUB:  tgt_lk = q.key_lk;
            TGT_CRT1, TGT_CRT2: tgt_lk = q.crt_lk;
            TGT_CNT:            tgt_lk = q.cnt_lk;
            default:            tgt_lk = 1'b0;
        endcase
    end

    always_comb begin
        d        = q;
        d.stat_v = 1'b0;
        t_start  = 1'b0;
        t_len    = CW'(1);
        we       = '0;
        wdata    = q.stage;
        op       = op_e'(cmd_op);
        accept   = cmd_valid && !busy;

        if (accept) begin
            d.pend = 1'b0;
            unique case (op)
                OP_LOAD: begin
                    if (dest_ok) begin
                        if (dec_tgt == TGT_CHAL) begin
                            we    = NUM_TGT'(1) << TGT_CHAL;
                            wdata = dec_data;
                        end else begin
                            d.pend     = 1'b1;
                            d.pend_tgt = dec_tgt;
                            d.stage    = dec_data;
                        end
                    end
                end
                OP_COPY: begin
                    t_start      = 1'b1;
                    d.job_prot   = PROT_NONE;
                    d.job_tgt    = q.pend_tgt;
                    d.job_hint   = cmd_param[7];
                    d.job_commit = 1'b0;
                    if (!q.pend) begin
                        d.job_stat = ST_NOSTAGE;
                    end else if (tgt_lk) begin
                        d.job_stat = ST_LOCKED;
                    end else begin
                        d.job_stat   = ST_DONE;
                        d.job_commit = 1'b1;
                        t_len = (q.pend_tgt == TGT_CNT) ? CW'(SHORT_LEN) : CW'(LONG_LEN);
                    end
                end
                OP_PROT: begin
                    if (cmd_param == PAR_LOCK_KEY || cmd_param == PAR_LOCK_CRT) begin
                        t_start      = 1'b1;
                        t_len        = CW'(SHORT_LEN);
                        d.job_commit = 1'b0;
                        d.job_stat   = ST_DONE;
                        d.job_prot   = (cmd_param == PAR_LOCK_KEY) ? PROT_KEY : PROT_CRT;
                    end
                end
                default: ;
            endcase
        end

        if (t_done) begin
            d.stat_v = 1'b1;
            d.stat   = q.job_stat;
            if (q.job_commit) begin
                we = NUM_TGT'(1) << q.job_tgt;
                if (q.job_tgt == TGT_PUB) d.hint   = q.job_hint;
                if (q.job_tgt == TGT_CNT) d.cnt_lk = 1'b1;
            end
            if (q.job_prot == PROT_KEY) d.key_lk = 1'b1;
            if (q.job_prot == PROT_CRT) d.crt_lk = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign status_valid = q.stat_v;
    assign status       = q.stat;
    assign key_locked   = q.key_lk;
    assign cert_locked  = q.crt_lk;
    assign hint_bit     = q.hint;

    assert_status_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> $past(busy));
    assert_status_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> (status == ST_DONE || status == ST_NOSTAGE || status == ST_LOCKED));
    assert_key_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_locked |=> key_locked);
    assert_cert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cert_locked |=> cert_locked);
    assert_hint_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(hint_bit));
    assert_pending_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op != OP_LOAD) |=> !q.pend);
    assert_counter_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (t_done && q.job_commit && q.job_tgt == TGT_CNT) |-> !q.cnt_lk);
endmodule

// File: tb/sbc_seq_tb.sv
module sbc_seq_tb_top;
    localparam int BW    = 256;
    localparam int LONGN = 80;
    localparam int SHRTN = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [7:0]    cmd_param = 8'h00;
    logic [BW-1:0] cmd_data = '0;
    logic          busy, status_valid, key_locked, cert_locked, hint_bit;
    logic [7:0]    status;
    logic [2:0]    rd_sel = 3'd0;
    logic [BW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int busy_n = 0;

    typedef struct {
        logic [7:0] st;
        int         len;
        string      req;
    } item_t;
    item_t sbq[$];

    logic [BW-1:0] em [6];

    always #4 clk = ~clk;

    sbc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_param(cmd_param), .cmd_data(cmd_data), .busy(busy),
        .status_valid(status_valid), .status(status), .key_locked(key_locked),
        .cert_locked(cert_locked), .hint_bit(hint_bit), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] pat(input int seed);
        logic [BW-1:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = 32'(seed) * 32'h9E3779B1 + 32'(i * 7 + 1);
        return v;
    endfunction

    function automatic logic [BW-1:0] mask(input int t, input logic [BW-1:0] v);
        int n;
        logic [BW-1:0] r;
        n = (t == 4) ? 32 : (t == 5) ? 4 : 24;
        r = '0;
        for (int b = 0; b < 32; b++) if (b < n) r[b*8 +: 8] = v[b*8 +: 8];
        return r;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_n++;
            if (status_valid) begin
                if (sbq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R8 unexpected status actual=%h expected=none", status);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk(status == it.st, {it.req, " status"}, BW'(status), BW'(it.st));
                    chk(busy_n == it.len, {"R6 busy length ", it.req}, BW'(busy_n), BW'(it.len));
                end
                busy_n = 0;
            end
        end
    end

    task automatic send(input logic [1:0] op, input logic [7:0] par, input logic [BW-1:0] dat);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_param = par; cmd_data = dat;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic copy_exp(input logic [7:0] par, input logic [7:0] st, input int len, input string req);
        item_t it;
        it.st = st; it.len = len; it.req = req;
        sbq.push_back(it);
        send(2'd2, par, '0);
        wait_idle();
    endtask

    task automatic rd_chk(input int t, input string req);
        rd_sel = 3'(t);
        #1;
        chk(rd_data === em[t], req, rd_data, em[t]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) em[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !status_valid, "R1 busy/status", BW'({busy, status_valid}), '0);
        chk(!key_locked && !cert_locked && !hint_bit, "R1 locks/hint", BW'({key_locked, cert_locked, hint_bit}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int t = 0; t < 6; t++) rd_chk(t, "R1 target zero");

        // R2 R5 private key
        send(2'd1, 8'h00, pat(1));
        copy_exp(8'h00, 8'hAA, LONGN, "R5 priv copy");
        em[0] = mask(0, pat(1));
        rd_chk(0, "R2 priv stored");

        // R4 copy without load
        copy_exp(8'h00, 8'h33, 1, "R4 no load");

        // R7 public key hint
        send(2'd1, 8'h20, pat(2));
        copy_exp(8'h80, 8'hAA, LONGN, "R5 pub copy");
        em[1] = mask(1, pat(2));
        rd_chk(1, "R2 pub stored");
        chk(hint_bit == 1'b1, "R7 hint set", BW'(hint_bit), BW'(1));
        send(2'd1, 8'h20, pat(3));
        copy_exp(8'h00, 8'hAA, LONGN, "R5 pub copy2");
        em[1] = mask(1, pat(3));
        chk(hint_bit == 1'b0, "R7 hint clear", BW'(hint_bit), BW'(0));
        send(2'd1, 8'h00, pat(4));
        copy_exp(8'h80, 8'hAA, LONGN, "R5 priv copy hint");
        em[0] = mask(0, pat(4));
        chk(hint_bit == 1'b0, "R7 hint untouched", BW'(hint_bit), BW'(0));

        // R11 command during busy
        send(2'd1, 8'h00, pat(5));
        begin
            item_t it;
            it.st = 8'hAA; it.len = LONGN; it.req = "R5 priv copy busy";
            sbq.push_back(it);
        end
        send(2'd2, 8'h00, '0);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_param = 8'h40; cmd_data = pat(6);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
        em[0] = mask(0, pat(5));
        copy_exp(8'h00, 8'h33, 1, "R11 ignored load");
        rd_chk(2, "R11 cert1 untouched");

        // certificates
        send(2'd1, 8'h40, pat(7));
        copy_exp(8'h00, 8'hAA, LONGN, "R5 cert1 copy");
        em[2] = mask(2, pat(7));
        rd_chk(2, "R2 cert1 stored");
        send(2'd1, 8'h60, pat(8));
        copy_exp(8'h00, 8'hAA, LONGN, "R5 cert2 copy");
        em[3] = mask(3, pat(8));
        rd_chk(3, "R2 cert2 stored");

        // R3 challenge
        send(2'd1, 8'h00, pat(9));
        send(2'd1, 8'h80, pat(10));
        em[4] = pat(10);
        rd_chk(4, "R3 challenge direct");
        copy_exp(8'h00, 8'h33, 1, "R3 challenge clears pending");
        rd_chk(0, "R4 priv unchanged");

        // R4 other command and failed copy between
        send(2'd1, 8'h00, pat(11));
        send(2'd0, 8'h00, '0);
        copy_exp(8'h00, 8'h33, 1, "R4 other cmd");
        copy_exp(8'h00, 8'h33, 1, "R4 after failed copy");

        // R12 unknown destination
        send(2'd1, 8'h00, pat(12));
        send(2'd1, 8'h10, pat(13));
        copy_exp(8'h00, 8'h33, 1, "R12 unknown clears");
        for (int t = 0; t < 6; t++) rd_chk(t, "R12 targets unchanged");

        // R10 counter
        send(2'd1, 8'hA0, pat(14));
        copy_exp(8'h00, 8'hAA, SHRTN, "R5 counter copy");
        em[5] = mask(5, pat(14));
        rd_chk(5, "R2 counter stored");
        send(2'd1, 8'hA0, pat(15));
        copy_exp(8'h00, 8'h55, 1, "R10 counter once");
        rd_chk(5, "R10 counter unchanged");

        // R8 protect unknown parameter
        send(2'd3, 8'h55, '0);
        repeat (4) @(negedge clk);
        chk(!busy && !key_locked && !cert_locked, "R8 unknown protect",
            BW'({busy, key_locked, cert_locked}), '0);

        // R8 R9 key lock
        begin
            item_t it;
            it.st = 8'hAA; it.len = SHRTN; it.req = "R8 key protect";
            sbq.push_back(it);
        end
        send(2'd3, 8'h4C, '0);
        wait_idle();
        chk(key_locked && !cert_locked, "R8 key lock", BW'({key_locked, cert_locked}), BW'(2'b10));
        send(2'd1, 8'h00, pat(16));
        copy_exp(8'h00, 8'h55, 1, "R9 priv locked");
        rd_chk(0, "R9 priv unchanged");
        send(2'd1, 8'h20, pat(17));
        copy_exp(8'h00, 8'h55, 1, "R9 pub locked");
        rd_chk(1, "R9 pub unchanged");
        chk(hint_bit == 1'b0, "R7 hint on locked copy", BW'(hint_bit), BW'(0));

        // R8 R9 cert lock
        begin
            item_t it;
            it.st = 8'hAA; it.len = SHRTN; it.req = "R8 cert protect";
            sbq.push_back(it);
        end
        send(2'd3, 8'h4D, '0);
        wait_idle();
        chk(cert_locked, "R8 cert lock", BW'(cert_locked), BW'(1));
        send(2'd1, 8'h60, pat(18));
        copy_exp(8'h00, 8'h55, 1, "R9 cert2 locked");
        rd_chk(3, "R9 cert2 unchanged");

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R6 all statuses seen", BW'(sbq.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule